// File: doc/BRIEF.md
# Exception Entry State Save Unit

This block carries out the architectural bookkeeping of a processor taking an exception. On a one-cycle take strobe it looks at the cause code, the current machine-state word and the next instruction address. It then decides which of three save pairs (standard, critical, hypervisor) receives the return address and the old state. It trims the old state word for the selected machine model and forms the state word the handler starts with. It also looks up the handler fetch address in a per-cause vector table, ORed with a prefix register.

A return strobe reads one of the save pairs back out. It produces the resume address with the low two bits cleared and a restored state word masked according to the kind of return. Causes that cannot be handled (the empty cause code, or a cause whose vector entry was never loaded) raise a one-cycle error flag and leave every pair untouched. A floating-point program exception that is disabled by the state word is dropped and reported on a separate flag.

Top module: `exc_entry_unit`

## Requirements
- R1: After reset all save pairs read zero, the done, error, ignore and return-valid flags are low, and every vector entry is all ones, so a take of any cause reports an error until its entry is loaded.
- R2: Cause codes are 0 none, 1 critical, 2 machine check, 3 data storage, 4 instruction storage, 5 external, 6 alignment, 7 program, 8 FP unavailable, 9 system call, 10 decrementer, 11 watchdog, 12 debug, 13 hypervisor decrementer, 14 vector unavailable, 15 facility unavailable. Causes 6, 8, 14, 15 and 7 save the faulting address (next address minus 4). A floating-point program exception with both enable bits set (bits 11 and 8) saves the next address, and every other cause saves the next address.
- R3: On the classic model (mode input 0) the saved state word has the bits under 0x783F0000 cleared before cause bits are added; on the embedded model (mode input 1) it is saved whole.
- R4: Program exceptions add a subtype bit to the saved word, with the kind input 0 floating point 0x00100000, 1 illegal 0x00080000, 2 privileged 0x00040000, 3 trap 0x00020000; floating point also adds 0x00010000 when enable bits 11 and 8 differ.
- R5: A floating-point program exception whose FP-available bit (bit 13) is clear or whose enable bits 11 and 8 are both clear raises the ignore flag one cycle later and changes no save pair.
- R6: The new state word keeps only the machine-check-enable bit (bit 12) of the old word; a machine check entry clears it too.
- R7: Critical causes, and the watchdog on the embedded model, save into the critical pair; the hypervisor decrementer saves into the hypervisor pair, sets bit 31 of the new state and carries bit 1 over from the old state; all other causes use the standard pair.
- R8: On the embedded model a machine check or debug entry writes the same address and state into the critical pair as into the standard pair.
- R9: One cycle after an accepted take, done pulses and the fetch address equals the cause's vector entry ORed with the prefix.
- R10: Cause 0, or a cause whose vector entry is all ones, pulses the error flag one cycle later with done low and no save pair changed.
- R11: A return strobe yields one cycle later the selected pair's address with bits 1:0 zero, and its state ANDed with a mask: kind 0 standard pair with 0x783F0000 cleared, kind 1 standard pair unmasked, kind 2 critical pair unmasked, kind 3 hypervisor pair with 0x783F0000 cleared.
- R12: When a take and a return are strobed in the same cycle, both complete, and the return delivers the pair contents held before that entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| take_i | input | 1 | Exception take strobe |
| cause_i | input | 4 | Cause code |
| prog_kind_i | input | 2 | Program exception subtype |
| emb_mode_i | input | 1 | 1 selects the embedded model |
| state_i | input | 32 | Current machine-state word |
| next_pc_i | input | ADDR_W | Next instruction address |
| vec_we_i | input | 1 | Vector entry write enable |
| vec_idx_i | input | 4 | Vector entry index |
| vec_data_i | input | ADDR_W | Vector entry value |
| prefix_we_i | input | 1 | Prefix write enable |
| prefix_i | input | ADDR_W | Prefix value |
| ret_i | input | 1 | Return strobe |
| ret_kind_i | input | 2 | Return kind |
| done_o | output | 1 | Entry accepted pulse |
| err_o | output | 1 | Invalid cause pulse |
| ign_o | output | 1 | Disabled FP exception pulse |
| new_state_o | output | 32 | Handler state word |
| fetch_addr_o | output | ADDR_W | Handler fetch address |
| std_addr_o | output | ADDR_W | Standard pair address |
| std_state_o | output | 32 | Standard pair state |
| crit_addr_o | output | ADDR_W | Critical pair address |
| crit_state_o | output | 32 | Critical pair state |
| hyp_addr_o | output | ADDR_W | Hypervisor pair address |
| hyp_state_o | output | 32 | Hypervisor pair state |
| ret_valid_o | output | 1 | Return result valid pulse |
| ret_addr_o | output | ADDR_W | Resume address |
| ret_state_o | output | 32 | Restored state word |

## Verification
An exception entry and a return from exception can land on the same clock edge. When they do, the pair being read may be the pair being written. The bench strobes both together, both in a directed case that returns from the very pair the entry targets and at random throughout the run. A reference model computes the return result from the pair contents before the entry, and then applies the entry. A design that forwards the freshly written values, or that drops either operation, disagrees with the model on the resume address or the restored state.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int WORD_W     = 32;
    localparam int CAUSE_W    = 4;
    localparam int NUM_CAUSES = 1 << CAUSE_W;
    localparam int NUM_PAIRS  = 3;

    // state word bit positions
    localparam int B_HV  = 31;
    localparam int B_FP  = 13;
    localparam int B_ME  = 12;
    localparam int B_FE0 = 11;
    localparam int B_FE1 = 8;
    localparam int B_RI  = 1;

    localparam logic [WORD_W-1:0] SAVE_CLR   = 32'h783F_0000;
    localparam logic [WORD_W-1:0] PB_FP      = 32'h0010_0000;
    localparam logic [WORD_W-1:0] PB_FP_IMPR = 32'h0001_0000;
    localparam logic [WORD_W-1:0] PB_ILL     = 32'h0008_0000;
    localparam logic [WORD_W-1:0] PB_PRIV    = 32'h0004_0000;
    localparam logic [WORD_W-1:0] PB_TRAP    = 32'h0002_0000;

    typedef enum logic [CAUSE_W-1:0] {
        C_NONE  = 4'd0,  C_CRIT  = 4'd1,  C_MCHK  = 4'd2,  C_DSTOR = 4'd3,
        C_ISTOR = 4'd4,  C_EXT   = 4'd5,  C_ALIGN = 4'd6,  C_PROG  = 4'd7,
        C_FPUN  = 4'd8,  C_SCALL = 4'd9,  C_DEC   = 4'd10, C_WDOG  = 4'd11,
        C_DBG   = 4'd12, C_HDEC  = 4'd13, C_VECUN = 4'd14, C_FACUN = 4'd15
    } cause_e;

    typedef enum logic [1:0] {
        PK_FP = 2'd0, PK_ILL = 2'd1, PK_PRIV = 2'd2, PK_TRAP = 2'd3
    } prog_e;

    typedef enum logic [1:0] {
        PAIR_STD = 2'd0, PAIR_CRIT = 2'd1, PAIR_HYP = 2'd2
    } pair_e;

    typedef enum logic [1:0] {
        RK_STD_MASKED = 2'd0, RK_STD_FULL = 2'd1, RK_CRIT = 2'd2, RK_HYP = 2'd3
    } ret_e;

    typedef struct packed {
        pair_e pair;
        logic  use_cur;
        logic  mirror;
        logic  hyp;
        logic  clr_me;
        logic  invalid;
    } route_t;

    function automatic logic [WORD_W-1:0] ret_mask(ret_e k);
        case (k)
            RK_STD_MASKED, RK_HYP: ret_mask = ~SAVE_CLR;
            default:               ret_mask = '1;
        endcase
    endfunction

    function automatic pair_e ret_pair(ret_e k);
        case (k)
            RK_CRIT: ret_pair = PAIR_CRIT;
            RK_HYP:  ret_pair = PAIR_HYP;
            default: ret_pair = PAIR_STD;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] prog_bits(prog_e k, logic fe0, logic fe1);
        case (k)
            PK_FP:   prog_bits = PB_FP | ((fe0 != fe1) ? PB_FP_IMPR : '0);
            PK_ILL:  prog_bits = PB_ILL;
            PK_PRIV: prog_bits = PB_PRIV;
            default: prog_bits = PB_TRAP;
        endcase
    endfunction

endpackage

// File: rtl/exc_route.sv
module exc_route
    import exc_pkg::*;
(
    input  cause_e             cause,
    input  logic               emb,
    input  prog_e              pkind,
    input  logic [WORD_W-1:0]  state,
    output route_t             rt
);
    always_comb begin
        rt.pair    = PAIR_STD;
        rt.use_cur = 1'b0;
        rt.mirror  = 1'b0;
        rt.hyp     = 1'b0;
        rt.clr_me  = 1'b0;
        rt.invalid = 1'b0;
        case (cause)
            C_NONE:  rt.invalid = 1'b1;
            C_CRIT:  rt.pair    = PAIR_CRIT;
            C_MCHK: begin
                rt.clr_me = 1'b1;
                rt.mirror = emb;
            end
            C_ALIGN, C_FPUN, C_VECUN, C_FACUN: rt.use_cur = 1'b1;
            // precise FP (enables differ) reports the faulting address
            C_PROG:  rt.use_cur = !(pkind == PK_FP && state[B_FE0] == state[B_FE1]);
            C_WDOG:  if (emb) rt.pair = PAIR_CRIT;
            C_DBG:   rt.mirror = emb;
            C_HDEC: begin
                rt.pair = PAIR_HYP;
                rt.hyp  = 1'b1;
            end
            default: ;
        endcase
    end

    // R7: hypervisor routing always pairs with the hypervisor flag
    always_comb begin
        a_r7_hyp_pair: assert ((rt.pair == PAIR_HYP) == rt.hyp);
    end
endmodule

// File: rtl/exc_state_build.sv
module exc_state_build
    import exc_pkg::*;
(
    input  logic [WORD_W-1:0]  state,
    input  logic               emb,
    input  logic               is_prog,
    input  prog_e              pkind,
    input  route_t             rt,
    output logic [WORD_W-1:0]  saved,
    output logic [WORD_W-1:0]  fresh,
    output logic               ignore
);
    logic fe0, fe1;
    assign fe0 = state[B_FE0];
    assign fe1 = state[B_FE1];

    assign ignore = is_prog && (pkind == PK_FP) && (!state[B_FP] || (!fe0 && !fe1));

    always_comb begin
        saved = emb ? state : (state & ~SAVE_CLR);
        if (is_prog)
            saved = saved | prog_bits(pkind, fe0, fe1);
    end

    always_comb begin
        fresh = '0;
        fresh[B_ME] = state[B_ME] && !rt.clr_me;
        if (rt.hyp) begin
            fresh[B_HV] = 1'b1;
            fresh[B_RI] = state[B_RI];
        end
    end
endmodule

// File: rtl/exc_vec_table.sv
module exc_vec_table
    import exc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [CAUSE_W-1:0] widx,
    input  logic [ADDR_W-1:0]  wdata,
    input  logic               pref_we,
    input  logic [ADDR_W-1:0]  pref_d,
    input  logic [CAUSE_W-1:0] ridx,
    output logic [ADDR_W-1:0]  handler,
    output logic               undefined
);
    logic [ADDR_W-1:0] entry_q [NUM_CAUSES];
    logic [ADDR_W-1:0] prefix_q;

    for (genvar i = 0; i < NUM_CAUSES; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst)
                entry_q[i] <= '1;
            else if (we && widx == CAUSE_W'(i))
                entry_q[i] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          prefix_q <= '0;
        else if (pref_we) prefix_q <= pref_d;
    end

    assign undefined = &entry_q[ridx];
    assign handler   = entry_q[ridx] | prefix_q;

    // R1: every entry starts out undefined
    a_r1_table_reset: assert property (@(posedge clk) $fell(rst) |-> &entry_q[0]);
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
    import exc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               take_i,
    input  logic [3:0]         cause_i,
    input  logic [1:0]         prog_kind_i,
    input  logic               emb_mode_i,
    input  logic [31:0]        state_i,
    input  logic [ADDR_W-1:0]  next_pc_i,
    input  logic               vec_we_i,
    input  logic [3:0]         vec_idx_i,
    input  logic [ADDR_W-1:0]  vec_data_i,
    input  logic               prefix_we_i,
    input  logic [ADDR_W-1:0]  prefix_i,
    input  logic               ret_i,
    input  logic [1:0]         ret_kind_i,
    output logic               done_o,
    output logic               err_o,
    output logic               ign_o,
    output logic [31:0]        new_state_o,
    output logic [ADDR_W-1:0]  fetch_addr_o,
    output logic [ADDR_W-1:0]  std_addr_o,
    output logic [31:0]        std_state_o,
    output logic [ADDR_W-1:0]  crit_addr_o,
    output logic [31:0]        crit_state_o,
    output logic [ADDR_W-1:0]  hyp_addr_o,
    output logic [31:0]        hyp_state_o,
    output logic               ret_valid_o,
    output logic [ADDR_W-1:0]  ret_addr_o,
    output logic [31:0]        ret_state_o
);
    localparam logic [ADDR_W-1:0] INSN_BYTES = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(3);

    cause_e            cause;
    prog_e             pkind;
    ret_e              rkind;
    route_t            rt;
    logic [WORD_W-1:0] saved_w, fresh_w;
    logic              ignore;
    logic [ADDR_W-1:0] handler;
    logic              vec_bad;
    logic [ADDR_W-1:0] save_addr;
    logic              ok_take, bad_take, ign_take;

    assign cause = cause_e'(cause_i);
    assign pkind = prog_e'(prog_kind_i);
    assign rkind = ret_e'(ret_kind_i);

    exc_route u_route (
        .cause (cause),
        .emb   (emb_mode_i),
        .pkind (pkind),
        .state (state_i),
        .rt    (rt)
    );

    exc_state_build u_build (
        .state   (state_i),
        .emb     (emb_mode_i),
        .is_prog (cause == C_PROG),
        .pkind   (pkind),
        .rt      (rt),
        .saved   (saved_w),
        .fresh   (fresh_w),
        .ignore  (ignore)
    );

    exc_vec_table #(.ADDR_W(ADDR_W)) u_vec (
        .clk       (clk),
        .rst       (rst),
        .we        (vec_we_i),
        .widx      (vec_idx_i),
        .wdata     (vec_data_i),
        .pref_we   (prefix_we_i),
        .pref_d    (prefix_i),
        .ridx      (cause_i),
        .handler   (handler),
        .undefined (vec_bad)
    );

    assign save_addr = rt.use_cur ? (next_pc_i - INSN_BYTES) : next_pc_i;
    assign ign_take  = take_i && !rt.invalid && ignore;
    assign bad_take  = take_i && (rt.invalid || (!ignore && vec_bad));
    assign ok_take   = take_i && !rt.invalid && !ignore && !vec_bad;

    // save pairs
    logic [ADDR_W-1:0] pair_addr_q  [NUM_PAIRS];
    logic [WORD_W-1:0] pair_state_q [NUM_PAIRS];

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        logic hit;
        assign hit = ok_take &&
                     ((rt.pair == pair_e'(p)) || (rt.mirror && pair_e'(p) == PAIR_CRIT));
        always_ff @(posedge clk) begin
            if (rst) begin
                pair_addr_q[p]  <= '0;
                pair_state_q[p] <= '0;
            end else if (hit) begin
                pair_addr_q[p]  <= save_addr;
                pair_state_q[p] <= saved_w;
            end
        end
    end

    // entry results
    always_ff @(posedge clk) begin
        if (rst) begin
            done_o       <= 1'b0;
            err_o        <= 1'b0;
            ign_o        <= 1'b0;
            new_state_o  <= '0;
            fetch_addr_o <= '0;
        end else begin
            done_o <= ok_take;
            err_o  <= bad_take;
            ign_o  <= ign_take;
            if (ok_take) begin
                new_state_o  <= fresh_w;
                fetch_addr_o <= handler;
            end
        end
    end

    // return path reads the pair contents before any same-cycle entry
    pair_e sel_pair;
    assign sel_pair = ret_pair(rkind);

    always_ff @(posedge clk) begin
        if (rst) begin
            ret_valid_o <= 1'b0;
            ret_addr_o  <= '0;
            ret_state_o <= '0;
        end else begin
            ret_valid_o <= ret_i;
            if (ret_i) begin
                ret_addr_o  <= pair_addr_q[sel_pair] & ALIGN_MASK;
                ret_state_o <= pair_state_q[sel_pair] & ret_mask(rkind);
            end
        end
    end

    assign std_addr_o   = pair_addr_q[PAIR_STD];
    assign std_state_o  = pair_state_q[PAIR_STD];
    assign crit_addr_o  = pair_addr_q[PAIR_CRIT];
    assign crit_state_o = pair_state_q[PAIR_CRIT];
    assign hyp_addr_o   = pair_addr_q[PAIR_HYP];
    assign hyp_state_o  = pair_state_q[PAIR_HYP];

    // R11: resume address is word aligned
    a_r11_ret_aligned: assert property (@(posedge clk) disable iff (rst)
        ret_valid_o |-> ret_addr_o[1:0] == 2'b00);

    // R6/R7: handler state holds only ME, HV and RI
    a_r6_new_state_bits: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (new_state_o & ~((32'd1 << B_ME) | (32'd1 << B_HV) | (32'd1 << B_RI))) == '0);

    // R10: the empty cause code is refused
    a_r10_none_cause: assert property (@(posedge clk) disable iff (rst)
        (take_i && cause_i == 4'd0) |=> (err_o && !done_o));

    // R9/R10/R5: at most one outcome per entry
    a_r9_one_outcome: assert property (@(posedge clk) disable iff (rst)
        $onehot0({done_o, err_o, ign_o}));

    // R5: a dropped FP exception leaves the pairs alone
    a_r5_ignore_no_save: assert property (@(posedge clk) disable iff (rst)
        ign_o |-> ($stable(std_addr_o) && $stable(std_state_o) && $stable(crit_addr_o)));

    // R8: embedded machine check mirrors into the critical pair
    a_r8_mirror: assert property (@(posedge clk) disable iff (rst)
        (take_i && cause_i == 4'd2 && emb_mode_i && !vec_bad) |=>
        (crit_addr_o == std_addr_o && crit_state_o == std_state_o));
endmodule

// File: tb/sim_exc_entry_unit.sv
module sim_exc_entry_unit;
    localparam int AW = 32;
    localparam logic [31:0] CLR = 32'h783F_0000;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst, take, emb, vwe, pwe, ret;
    logic [3:0] cause, vidx;
    logic [1:0] pk, rk;
    logic [31:0] st;
    logic [AW-1:0] npc, vdata, pdata;
    logic done, err, ign, rv;
    logic [31:0] ns, sst, cst, hst, rs;
    logic [AW-1:0] fa, sa, ca, ha, ra;

    exc_entry_unit #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst(rst), .take_i(take), .cause_i(cause), .prog_kind_i(pk),
        .emb_mode_i(emb), .state_i(st), .next_pc_i(npc), .vec_we_i(vwe),
        .vec_idx_i(vidx), .vec_data_i(vdata), .prefix_we_i(pwe), .prefix_i(pdata),
        .ret_i(ret), .ret_kind_i(rk), .done_o(done), .err_o(err), .ign_o(ign),
        .new_state_o(ns), .fetch_addr_o(fa), .std_addr_o(sa), .std_state_o(sst),
        .crit_addr_o(ca), .crit_state_o(cst), .hyp_addr_o(ha), .hyp_state_o(hst),
        .ret_valid_o(rv), .ret_addr_o(ra), .ret_state_o(rs)
    );

    int total = 0;
    int bad = 0;

    // reference model
    logic [AW-1:0] m_addr [3];
    logic [31:0]   m_st   [3];
    logic [AW-1:0] m_vec  [16];
    logic [AW-1:0] m_pref;
    logic e_done, e_err, e_ign, e_rv;
    logic [31:0] e_ns, e_rs;
    logic [AW-1:0] e_fa, e_ra;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 3; i++) begin m_addr[i] = '0; m_st[i] = '0; end
        for (int i = 0; i < 16; i++) m_vec[i] = '1;
        m_pref = '0;
        e_done = 0; e_err = 0; e_ign = 0; e_rv = 0;
    endtask

    task automatic predict();
        logic fe0, fe1, isfp, ig, inv, badv, cur, mir;
        logic [31:0] sw, nw;
        logic [AW-1:0] adr;
        int p;
        // return first, from contents before this cycle's entry (R11, R12)
        e_rv = ret;
        if (ret) begin
            p = (rk == 2'd2) ? 1 : (rk == 2'd3) ? 2 : 0;
            e_ra = m_addr[p] & ~AW'(3);
            e_rs = m_st[p] & ((rk == 2'd0 || rk == 2'd3) ? ~CLR : 32'hFFFF_FFFF);
        end
        fe0 = st[11]; fe1 = st[8];
        inv = (cause == 4'd0);
        isfp = (cause == 4'd7) && (pk == 2'd0);
        ig = isfp && (!st[13] || (!fe0 && !fe1));
        badv = &m_vec[cause];
        e_err  = take && (inv || (!ig && badv));
        e_ign  = take && !inv && ig;
        e_done = take && !inv && !ig && !badv;
        if (e_done) begin
            cur = (cause == 4'd6) || (cause == 4'd8) || (cause == 4'd14) || (cause == 4'd15) ||
                  ((cause == 4'd7) && !(isfp && fe0 == fe1));
            adr = cur ? npc - AW'(4) : npc;
            sw = emb ? st : (st & ~CLR);
            if (cause == 4'd7) begin
                case (pk)
                    2'd0: sw = sw | 32'h0010_0000 | ((fe0 != fe1) ? 32'h0001_0000 : 32'h0);
                    2'd1: sw = sw | 32'h0008_0000;
                    2'd2: sw = sw | 32'h0004_0000;
                    default: sw = sw | 32'h0002_0000;
                endcase
            end
            nw = '0;
            nw[12] = st[12] && (cause != 4'd2);
            p = 0;
            if (cause == 4'd1 || (cause == 4'd11 && emb)) p = 1;
            if (cause == 4'd13) begin
                p = 2; nw[31] = 1'b1; nw[1] = st[1];
            end
            mir = emb && (cause == 4'd2 || cause == 4'd12);
            m_addr[p] = adr; m_st[p] = sw;
            if (mir) begin m_addr[1] = adr; m_st[1] = sw; end
            e_ns = nw;
            e_fa = m_vec[cause] | m_pref;
        end
        if (vwe) m_vec[vidx] = vdata;
        if (pwe) m_pref = pdata;
    endtask

    task automatic compare_all(input string tag);
        chk({tag, " done"}, done, e_done);
        chk({tag, " err"}, err, e_err);
        chk({tag, " ign"}, ign, e_ign);
        chk({tag, " ret_valid"}, rv, e_rv);
        if (e_done) begin
            chk({tag, " new_state"}, ns, e_ns);
            chk({tag, " fetch"}, fa, e_fa);
        end
        if (e_rv) begin
            chk({tag, " ret_addr"}, ra, e_ra);
            chk({tag, " ret_state"}, rs, e_rs);
        end
        chk({tag, " std_addr"}, sa, m_addr[0]);
        chk({tag, " std_state"}, sst, m_st[0]);
        chk({tag, " crit_addr"}, ca, m_addr[1]);
        chk({tag, " crit_state"}, cst, m_st[1]);
        chk({tag, " hyp_addr"}, ha, m_addr[2]);
        chk({tag, " hyp_state"}, hst, m_st[2]);
    endtask

    task automatic idle();
        take = 0; ret = 0; vwe = 0; pwe = 0;
        cause = 0; pk = 0; rk = 0; vidx = 0;
    endtask

    task automatic step(input string tag);
        predict();
        @(posedge clk);
        @(negedge clk);
        compare_all(tag);
        idle();
    endtask

    task automatic do_take(input string tag, input logic [3:0] c, input logic [1:0] k,
                           input logic e, input logic [31:0] s, input logic [AW-1:0] pc);
        take = 1; cause = c; pk = k; emb = e; st = s; npc = pc;
        step(tag);
    endtask

    logic finished = 0;

    initial begin
        #(64'd20 * 64'd200000);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        idle();
        emb = 0; st = 0; npc = 0; vdata = 0; pdata = 0;
        rst = 1;
        model_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset state
        compare_all("R1 reset");
        do_take("R1 R10 unloaded entry", 4'd3, 2'd0, 1'b0, 32'h0000_1000, 32'h0000_2000);

        // load every entry except the decrementer, then the prefix
        for (int i = 1; i < 16; i++) begin
            if (i != 10) begin
                vwe = 1; vidx = 4'(i); vdata = 32'h0000_0100 * i;
                step("R9 load");
            end
        end
        pwe = 1; pdata = 32'hFFF0_0000;
        step("R9 prefix");

        do_take("R10 none cause", 4'd0, 2'd0, 1'b0, 32'h0000_1000, 32'h100);
        do_take("R10 undefined entry", 4'd10, 2'd0, 1'b0, 32'h0000_1000, 32'h104);
        do_take("R9 R2 R3 dstor classic", 4'd3, 2'd0, 1'b0, 32'hFFFF_FFFF, 32'h0000_4000);
        do_take("R2 R3 align embedded", 4'd6, 2'd0, 1'b1, 32'hFFFF_FFFF, 32'h0000_5000);
        do_take("R5 fp unavailable", 4'd7, 2'd0, 1'b0, 32'h0000_0900, 32'h600);
        do_take("R5 fp enables off", 4'd7, 2'd0, 1'b0, 32'h0000_2000, 32'h604);
        do_take("R4 R2 fp precise", 4'd7, 2'd0, 1'b0, 32'h0000_2800, 32'h0000_7000);
        do_take("R4 R2 fp both enables", 4'd7, 2'd0, 1'b0, 32'h0000_2900, 32'h0000_7100);
        do_take("R4 illegal", 4'd7, 2'd1, 1'b0, 32'h783F_1000, 32'h0000_7200);
        do_take("R4 privileged", 4'd7, 2'd2, 1'b0, 32'h0, 32'h0000_7300);
        do_take("R4 trap", 4'd7, 2'd3, 1'b1, 32'h0, 32'h0000_7400);
        do_take("R6 R8 mcheck embedded", 4'd2, 2'd0, 1'b1, 32'h0000_1002, 32'h0000_8000);
        do_take("R6 mcheck classic", 4'd2, 2'd0, 1'b0, 32'h0000_1000, 32'h0000_8100);
        do_take("R8 debug embedded", 4'd12, 2'd0, 1'b1, 32'h0000_0055, 32'h0000_8200);
        do_take("R7 critical", 4'd1, 2'd0, 1'b0, 32'h0000_1234, 32'h0000_9000);
        do_take("R7 watchdog embedded", 4'd11, 2'd0, 1'b1, 32'h0000_4321, 32'h0000_9100);
        do_take("R7 watchdog classic", 4'd11, 2'd0, 1'b0, 32'h0000_4321, 32'h0000_9200);
        do_take("R7 hyp decrementer", 4'd13, 2'd0, 1'b0, 32'h7FFF_F003, 32'h0000_A003);
        for (int k = 0; k < 4; k++) begin
            ret = 1; rk = 2'(k);
            step("R11 return kind");
        end
        // R12: entry and return on the same pair in one cycle
        ret = 1; rk = 2'd3;
        do_take("R12 take with return", 4'd13, 2'd0, 1'b0, 32'h0000_1002, 32'h0000_B000);
        ret = 1; rk = 2'd1;
        do_take("R12 take with return std", 4'd5, 2'd0, 1'b0, 32'h0000_1000, 32'h0000_C000);

        for (int n = 0; n < 3000; n++) begin
            take = ($urandom % 4) != 0;
            cause = 4'($urandom);
            pk = 2'($urandom);
            emb = 1'($urandom);
            st = $urandom;
            npc = $urandom;
            ret = ($urandom % 4) == 0;
            rk = 2'($urandom);
            step("rand R2 R3 R4 R6 R7 R9 R11 R12");
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule